// File: doc/BRIEF.md
# Locality Ownership Claim Engine

This engine claims one locality of a memory-mapped security-module register window on behalf of host logic. A single-cycle start pulse launches the sequence. The engine reads the locality control byte at offset 0 to confirm that a device answers. If the read returns all ones, no device is present and the engine stops there. Otherwise it writes the request-use command and then re-reads the control byte until two conditions hold together: the register reports valid, and the locality reports active. If the polling budget runs out first, it stops with a timeout.

The engine drives a byte-wide register master port. An address is held with a read or write strobe until the slave raises ready. A free-running one-microsecond tick paces the polling. `POLL_US` sets the interval between re-reads and `TIMEOUT_US` sets the total budget. The defaults are 30 us and 1 s. A testbench can shrink both.

Completion is a one-cycle `done` pulse carrying a 2-bit result code.

Top module: `acc_claim_top`

## Requirements
- R1: After synchronous active-high reset the engine is idle: `done`, `bus_rd` and `bus_wr` are all 0.
- R2: After start, the first bus transaction is a read of address 0. If it returns 0xFF, the engine finishes with result 1 (not found) and performs no write.
- R3: If the first read returns anything other than 0xFF, the engine performs exactly one write of 0x02 (bit 1 set) to address 0.
- R4: After that write, the engine reads address 0. When a read returns bit 7 and bit 5 both equal to 1, the engine finishes with result 0 (success) and makes no further access.
- R5: A poll value with only one of bit 7 or bit 5 set, or neither, is not success, and polling continues.
- R6: Between two consecutive poll reads the engine waits at least `POLL_US` microsecond ticks.
- R7: If no poll succeeds, the engine makes exactly ceil(`TIMEOUT_US`/`POLL_US`) poll reads and then finishes with result 2 (timeout).
- R8: `done` is high for exactly one cycle per started request, and `result` is 0, 1 or 2 while `done` is high.
- R9: A start pulse while a request is in progress is ignored: no extra transaction occurs and no extra `done` appears.
- R10: At most one strobe is active at a time. A strobe stays asserted, with address and write data unchanged, until `bus_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to claim the locality |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| bus_addr | output | ADDR_W | Register byte address |
| bus_rd | output | 1 | Read strobe, held until ready |
| bus_wr | output | 1 | Write strobe, held until ready |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid with ready |
| bus_ready | input | 1 | Slave completes the current access |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 success, 1 not found, 2 timeout; valid with done |

## Verification
A wrong sequencer state shows at the ports within one access. Examples are a write that still appears after an all-ones probe, a second request write, or a poll read that should never have been issued. The bench counts every read and write, so the error shows in the totals for that run.

A fault in the interval or budget counters changes the number of poll reads before a timeout, or the tick spacing between reads. Both are compared against the arithmetic value the bench computes for each of several latencies and flag patterns.

A fault in the flag decode shows up as the wrong result code on the very `done` pulse that ends the request.

// File: rtl/acc_claim_pkg.sv
package acc_claim_pkg;

    localparam logic [7:0] ABSENT_VALUE = 8'hFF;
    localparam logic [7:0] REQUEST_CMD  = 8'h02;
    localparam int         BIT_VALID    = 7;
    localparam int         BIT_ACTIVE   = 5;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_ABSENT  = 2'd1,
        RES_TIMEOUT = 2'd2
    } claim_res_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROBE,
        ST_REQ,
        ST_POLL,
        ST_WAIT,
        ST_DONE
    } claim_st_e;

    typedef struct packed {
        logic absent;
        logic owned;
    } flag_view_t;

    function automatic flag_view_t decode_flags(input logic [7:0] v);
        flag_view_t f;
        f.absent = (v == ABSENT_VALUE);
        f.owned  = v[BIT_VALID] & v[BIT_ACTIVE];
        return f;
    endfunction

endpackage

// File: rtl/acc_flag_check.sv
module acc_flag_check
    import acc_claim_pkg::*;
(
    input  logic [7:0] rdata,
    output flag_view_t view
);
    always_comb view = decode_flags(rdata);
endmodule

// File: rtl/acc_poll_timer.sv
module acc_poll_timer #(
    parameter int POLL_US    = 30,
    parameter int TIMEOUT_US = 1000000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    input  logic us_tick,
    output logic interval_end,
    output logic budget_spent
);
    localparam int PW = (POLL_US > 1) ? $clog2(POLL_US) : 1;
    localparam int BW = $clog2(TIMEOUT_US + POLL_US + 1);
    localparam logic [PW-1:0] P_LAST  = PW'(POLL_US - 1);
    localparam logic [BW-1:0] P_STEP  = BW'(POLL_US);
    localparam logic [BW-1:0] T_LIMIT = BW'(TIMEOUT_US);

    logic [PW-1:0] tick_cnt;
    logic [BW-1:0] spent_us;
    logic          wrap;

    assign wrap = run && us_tick && (tick_cnt == P_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_cnt     <= '0;
            spent_us     <= '0;
            interval_end <= 1'b0;
        end else begin
            interval_end <= wrap;
            if (!run)
                tick_cnt <= '0;
            else if (wrap)
                tick_cnt <= '0;
            else if (us_tick)
                tick_cnt <= tick_cnt + 1'b1;
            if (clear)
                spent_us <= '0;
            else if (wrap && spent_us < T_LIMIT)
                spent_us <= spent_us + P_STEP;
        end
    end

    assign budget_spent = (spent_us >= T_LIMIT);
endmodule

// File: rtl/acc_claim_fsm.sv
module acc_claim_fsm
    import acc_claim_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       bus_ready,
    input  flag_view_t view,
    input  logic       interval_end,
    input  logic       budget_spent,
    output claim_st_e  state,
    output claim_res_e res_q,
    output logic       tmr_clear,
    output logic       tmr_run
);
    claim_st_e  nxt;
    claim_res_e res_n;

    always_comb begin
        nxt   = state;
        res_n = res_q;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_PROBE;
            ST_PROBE: if (bus_ready) begin
                if (view.absent) begin
                    nxt   = ST_DONE;
                    res_n = RES_ABSENT;
                end else begin
                    nxt = ST_REQ;
                end
            end
            ST_REQ:   if (bus_ready) nxt = ST_POLL;
            ST_POLL:  if (bus_ready) begin
                if (view.owned) begin
                    nxt   = ST_DONE;
                    res_n = RES_OK;
                end else begin
                    nxt = ST_WAIT;
                end
            end
            ST_WAIT:  if (interval_end) begin
                if (budget_spent) begin
                    nxt   = ST_DONE;
                    res_n = RES_TIMEOUT;
                end else begin
                    nxt = ST_POLL;
                end
            end
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            res_q <= RES_OK;
        end else begin
            state <= nxt;
            res_q <= res_n;
        end
    end

    assign tmr_clear = (state == ST_REQ);
    assign tmr_run   = (state == ST_WAIT);
endmodule

// File: rtl/acc_claim_top.sv
module acc_claim_top
    import acc_claim_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int POLL_US    = 30,
    parameter int TIMEOUT_US = 1000000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              us_tick,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [7:0]        bus_wdata,
    input  logic [7:0]        bus_rdata,
    input  logic              bus_ready,
    output logic              done,
    output logic [1:0]        result
);
    localparam logic [ADDR_W-1:0] CTRL_OFFSET = '0;

    flag_view_t view;
    claim_st_e  state;
    claim_res_e res_q;
    logic       tmr_clear, tmr_run, interval_end, budget_spent;

    acc_flag_check u_flags (
        .rdata (bus_rdata),
        .view  (view)
    );

    acc_poll_timer #(
        .POLL_US    (POLL_US),
        .TIMEOUT_US (TIMEOUT_US)
    ) u_timer (
        .clk          (clk),
        .rst          (rst),
        .clear        (tmr_clear),
        .run          (tmr_run),
        .us_tick      (us_tick),
        .interval_end (interval_end),
        .budget_spent (budget_spent)
    );

    acc_claim_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .bus_ready    (bus_ready),
        .view         (view),
        .interval_end (interval_end),
        .budget_spent (budget_spent),
        .state        (state),
        .res_q        (res_q),
        .tmr_clear    (tmr_clear),
        .tmr_run      (tmr_run)
    );

    assign bus_addr  = CTRL_OFFSET;
    assign bus_rd    = (state == ST_PROBE) || (state == ST_POLL);
    assign bus_wr    = (state == ST_REQ);
    assign bus_wdata = bus_wr ? REQUEST_CMD : 8'h00;
    assign done      = (state == ST_DONE);
    assign result    = res_q;
endmodule

// File: rtl/acc_claim_chk.sv
module acc_claim_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              bus_ready,
    input logic              done,
    input logic [1:0]        result
);
    p_one_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr));

    p_rd_held_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_ready) |=> bus_rd && $stable(bus_addr));

    p_wr_held_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_ready) |=> bus_wr && $stable(bus_addr) && $stable(bus_wdata));

    p_req_value_r3: assert property (@(posedge clk) disable iff (rst)
        bus_wr |-> (bus_wdata == 8'h02) && (bus_addr == '0));

    p_rd_offset_r4: assert property (@(posedge clk) disable iff (rst)
        bus_rd |-> (bus_addr == '0));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_result_code_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (result != 2'd3));

    p_ok_flags_r4: assert property (@(posedge clk) disable iff (rst)
        (done && result == 2'd0) |->
            $past(bus_rd && bus_ready && bus_rdata[7] && bus_rdata[5]));

    p_absent_r2: assert property (@(posedge clk) disable iff (rst)
        (done && result == 2'd1) |-> $past(bus_rd && bus_ready && bus_rdata == 8'hFF));

    p_quiet_done_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !bus_rd && !bus_wr);
endmodule

bind acc_claim_top acc_claim_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_ready (bus_ready),
    .done      (done),
    .result    (result)
);

// File: tb/sim_acc_claim_top.sv
`timescale 1ns/1ps
module sim_acc_claim_top;
    localparam int AW    = 12;
    localparam int POLL  = 3;
    localparam int TMO   = 10;
    localparam int NPOLL = (TMO + POLL - 1) / POLL;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic us_tick = 1'b0;
    logic [AW-1:0] bus_addr;
    logic bus_rd, bus_wr, bus_ready;
    logic [7:0] bus_wdata, bus_rdata;
    logic done;
    logic [1:0] result;

    always #2 clk = ~clk;

    acc_claim_top #(.ADDR_W(AW), .POLL_US(POLL), .TIMEOUT_US(TMO)) u0 (
        .clk(clk), .rst(rst), .start(start), .us_tick(us_tick),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .done(done), .result(result)
    );

    int checks = 0;
    int fails  = 0;

    logic [7:0] probe_val, bad_val;
    int good_after, lat;
    int n_rd, n_wr, n_done, bad_wr, lat_cnt, ticks_since, min_gap;
    logic ready_q;
    logic [7:0] rdata_q;
    int tdiv;

    assign bus_ready = ready_q;
    assign bus_rdata = rdata_q;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            ready_q <= 1'b0; rdata_q <= 8'h00; lat_cnt <= 0; tdiv <= 0; us_tick <= 1'b0;
        end else begin
            tdiv    <= (tdiv == 3) ? 0 : tdiv + 1;
            us_tick <= (tdiv == 3);
            if (us_tick) ticks_since <= ticks_since + 1;
            if (done) n_done <= n_done + 1;
            if (ready_q) begin
                ready_q <= 1'b0;
            end else if (bus_rd || bus_wr) begin
                if (lat_cnt >= lat) begin
                    lat_cnt <= 0;
                    ready_q <= 1'b1;
                    if (bus_wr) begin
                        n_wr <= n_wr + 1;
                        if (bus_wdata != 8'h02 || bus_addr != '0) bad_wr <= bad_wr + 1;
                    end else begin
                        n_rd <= n_rd + 1;
                        if (n_rd == 0) rdata_q <= probe_val;
                        else rdata_q <= (n_rd - 1 < good_after) ? bad_val : 8'hA0;
                        if (n_rd >= 2 && ticks_since < min_gap) min_gap <= ticks_since;
                        ticks_since <= 0;
                    end
                end else begin
                    lat_cnt <= lat_cnt + 1;
                end
            end
        end
    end

    task automatic run_case(input logic [7:0] pv, input logic [7:0] bv, input int ga,
                            input int l, input bit poke, input int exp_res,
                            input int exp_rd, input int exp_wr, input string tag);
        int cyc;
        int res;
        probe_val = pv; bad_val = bv; good_after = ga; lat = l;
        n_rd = 0; n_wr = 0; n_done = 0; bad_wr = 0; ticks_since = 0; min_gap = 1000;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        cyc = 0; res = -1;
        while (!done && cyc < 2000) begin
            if (poke && n_wr == 1 && cyc[2:0] == 3'd5) begin
                start = 1'b1; @(negedge clk); start = 1'b0;
            end else @(negedge clk);
            cyc++;
        end
        res = done ? int'(result) : -1;
        check(res == exp_res, {tag, " result"}, res, exp_res);
        @(negedge clk);
        check(done == 1'b0, "R8 done width", int'(done), 0);
        repeat (40) @(negedge clk);
        check(n_rd == exp_rd, {tag, " reads"}, n_rd, exp_rd);
        check(n_wr == exp_wr, {tag, " writes"}, n_wr, exp_wr);
        check(n_done == 1, "R8/R9 done count", n_done, 1);
        check(bad_wr == 0, "R3 write value", bad_wr, 0);
        if (exp_rd >= 3)
            check(min_gap >= POLL, "R6 poll spacing", min_gap, POLL);
    endtask

    initial begin
        probe_val = 8'h00; bad_val = 8'h00; good_after = 0; lat = 0;
        n_rd = 0; n_wr = 0; n_done = 0; bad_wr = 0; ticks_since = 0; min_gap = 1000;
        repeat (3) @(negedge clk);
        check(done == 1'b0 && bus_rd == 1'b0 && bus_wr == 1'b0, "R1 reset idle",
              int'({done, bus_rd, bus_wr}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(done == 1'b0 && bus_rd == 1'b0 && bus_wr == 1'b0, "R1 idle after reset",
              int'({done, bus_rd, bus_wr}), 0);
        for (int l = 0; l < 3; l++) begin
            run_case(8'hFF, 8'h00, 0, l, 1'b0, 1, 1, 0, "R2 absent");
            run_case(8'h81, 8'h00, 0, l, 1'b0, 0, 2, 1, "R3/R4 immediate");
            for (int k = 1; k < NPOLL; k++) begin
                run_case(8'h00, 8'h80, k, l, 1'b0, 0, 2 + k, 1, "R5 valid-only");
                run_case(8'h7F, 8'h20, k, l, 1'b0, 0, 2 + k, 1, "R5 active-only");
            end
            run_case(8'hFE, 8'h5F, 1000, l, 1'b0, 2, 1 + NPOLL, 1, "R7 timeout");
        end
        run_case(8'h00, 8'h00, 2, 1, 1'b1, 0, 4, 1, "R9 busy start");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule